// File: doc/BRIEF.md
# Serial-Peripheral EEPROM Target

This block models a small byte-addressed serial EEPROM as seen from the memory side of an SPI link (mode 0). A host drives chip select (active low), the serial clock and serial data in. The block drives serial data out. Every frame opens with a one-byte command. That command may set or clear a write-enable latch, read that latch back as a status byte, accept and throw away a status write, or start a streamed read or write of the internal 4096-byte array at a 16-bit address. A streamed access keeps moving through consecutive locations for as long as the host keeps clocking. Each byte written is stored as soon as its eighth bit arrives.

All logic runs on one system clock. Chip select, serial clock and serial data in are each brought in through a two-flop synchronizer, so the serial clock must stay high and stay low for at least four system clocks in each phase. After reset the array fills itself with 0xFF, one location per clock, and the serial side does nothing until the fill is complete (4096 system clocks). A debug read port gives the array contents with one clock of latency.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, serial out is 0 and the write-enable latch is clear. Once the fill has finished, every array location reads 0xFF. No command is taken before the fill ends.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 then returns a status byte whose bit 1 is the latch and whose other bits are 0. After that byte the next byte is decoded as a new command.
- R3: Any command byte other than 0x01 to 0x06 leaves the latch unchanged and keeps the engine in command decode, so the next byte is taken as a command.
- R4: Command 0x02 with the latch set is followed by a 16-bit address, sent most significant bit first. Only the low 12 bits are used. Every later full byte is stored at the current address, and the address then advances, going from 0xFFF to 0x000.
- R5: Command 0x02 with the latch clear stores nothing. The engine stays in command decode, so the following bytes are decoded as commands.
- R6: Command 0x01 with the latch set swallows the next 8 bits without effect and then returns to command decode. With the latch clear, 0x01 is ignored in the same way as R5. Commands 0x01 and 0x02 both clear the latch, whether or not they are accepted.
- R7: Command 0x03 is followed by a 16-bit address of which only the low 12 bits are used. Bytes are then streamed out from consecutive locations, most significant bit first, and the address goes from 0xFFF to 0x000. Bit j of an outgoing byte is on serial out after rising clock edge 8-j of that byte. A read leaves the latch unchanged.
- R8: Serial out is 0 except while a read stream or a status byte is being sent. That includes the command and address bytes, writes, and any time chip select is high.
- R9: Raising chip select in the middle of a byte ends the frame. The partial byte is dropped, a partial write byte is not stored, and the next frame starts with a fresh command byte.
- R10: The debug port returns the array byte at dbg_addr one system clock later.
- R11: Serial clock and data activity while chip select is high has no effect on the latch or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| dbg_addr | input | 12 | Debug read address |
| dbg_data | output | 8 | Array byte at the debug address, one clock later |

## Verification
The hardest cases to reach from the ports are the ones that depend on the engine staying in command decode. A write or status-write command with the latch clear leaves the following address or data bytes to be taken as commands. A chip-select abort in the middle of a byte must also realign the bit counter. The bench covers these with multi-command frames in which a later byte in the same frame (0x06, 0x05) only has a visible effect if the earlier command was rejected. It also sends partial frames and then checks the status byte. The address wrap is reached with addresses near 0xFFF whose upper address bits are set, so the 12-bit mask and the carry out of the top location are both exercised.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT_WR,
    ST_STAT_RD,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_ADDR,
    ST_WR_DATA
  } eng_state_t;

  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_DATA_WR  = 8'h02;
  localparam logic [7:0] OP_DATA_RD  = 8'h03;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int         AW   = 12,
  parameter int         DW   = 8,
  parameter logic [DW-1:0] FILL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ready,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   sweep_q, sweep_d;
  logic          sweep_en;

  assign ready    = sweep_q[AW];
  assign sweep_en = !sweep_q[AW];

  always_comb begin
    sweep_d = sweep_q;
    if (sweep_en) begin
      sweep_d = sweep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= '0;
    end else begin
      sweep_q <= sweep_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sweep_en) begin
      mem[sweep_q[AW-1:0]] <= FILL;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/eep_engine.sv
module eep_engine
  import eep_pkg::*;
#(
  parameter int AW    = 12,
  parameter int BW    = 8,
  parameter int ABITS = 16,
  localparam int CW   = $clog2(ABITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          mosi,
  output logic          miso,
  output logic          we,
  output logic [BW-1:0] wdata,
  output logic [AW-1:0] addr_o,
  input  logic [BW-1:0] rdata,
  output eng_state_t    st_o,
  output logic [CW-1:0] cnt_o,
  output logic [BW-2:0] shlo_o,
  output logic          wel_o
);

  localparam logic [CW-1:0] LAST_BYTE = CW'(BW - 1);
  localparam logic [CW-1:0] LAST_ADDR = CW'(ABITS - 1);

  eng_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-2:0] shin_q, shin_d;
  logic [AW-1:0] shin_nx;
  logic [BW:0]   shout_q, shout_d;
  logic          wel_q, wel_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [1:0]    ld_q, ld_d;
  logic          step;
  logic          byte_end, addr_end;

  assign step     = cs_act && ready && sck_rise;
  assign shin_nx  = {shin_q, mosi};
  assign byte_end = (cnt_q == LAST_BYTE);
  assign addr_end = (cnt_q == LAST_ADDR);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    shin_d  = shin_q;
    shout_d = shout_q;
    wel_d   = wel_q;
    addr_d  = addr_q;
    ld_d    = {ld_q[0], 1'b0};
    we      = 1'b0;
    wdata   = shin_nx[BW-1:0];

    if (ld_q[1]) begin
      shout_d[BW-1:0] = rdata;
    end

    if (!cs_act) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (step) begin
      shin_d = shin_nx[AW-2:0];
      cnt_d  = cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (byte_end) begin
            cnt_d = '0;
            case (shin_nx[BW-1:0])
              OP_STAT_WR: begin
                if (wel_q) st_d = ST_STAT_WR;
                wel_d = 1'b0;
              end
              OP_DATA_WR: begin
                if (wel_q) st_d = ST_WR_ADDR;
                wel_d = 1'b0;
              end
              OP_DATA_RD:   st_d = ST_RD_ADDR;
              OP_LATCH_CLR: wel_d = 1'b0;
              OP_STAT_RD: begin
                st_d    = ST_STAT_RD;
                shout_d = {{(BW-1){1'b0}}, wel_q, 1'b0};
              end
              OP_LATCH_SET: wel_d = 1'b1;
              default: ;
            endcase
          end
        end
        ST_STAT_WR: begin
          if (byte_end) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        ST_STAT_RD: begin
          shout_d = {shout_q[BW-1:0], 1'b0};
          if (byte_end) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        ST_RD_ADDR: begin
          if (addr_end) begin
            addr_d  = shin_nx;
            shout_d = '0;
            ld_d[0] = 1'b1;
            st_d    = ST_RD_DATA;
            cnt_d   = '0;
          end
        end
        ST_RD_DATA: begin
          shout_d = {shout_q[BW-1:0], 1'b0};
          if (byte_end) begin
            addr_d  = addr_q + 1'b1;
            ld_d[0] = 1'b1;
            cnt_d   = '0;
          end
        end
        ST_WR_ADDR: begin
          if (addr_end) begin
            addr_d = shin_nx;
            st_d   = ST_WR_DATA;
            cnt_d  = '0;
          end
        end
        ST_WR_DATA: begin
          if (byte_end) begin
            we     = 1'b1;
            addr_d = addr_q + 1'b1;
            cnt_d  = '0;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      wel_q   <= 1'b0;
      addr_q  <= '0;
      ld_q    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      shin_q  <= shin_d;
      shout_q <= shout_d;
      wel_q   <= wel_d;
      addr_q  <= addr_d;
      ld_q    <= ld_d;
    end
  end

  assign miso   = ((st_q == ST_RD_DATA) || (st_q == ST_STAT_RD)) ? shout_q[BW] : 1'b0;
  assign addr_o = addr_q;
  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign shlo_o = shin_q[BW-2:0];
  assign wel_o  = wel_q;

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eep_pkg::*;
#(
  parameter int AW    = 12,
  parameter int BW    = 8,
  parameter int ABITS = 16,
  localparam int CW   = $clog2(ABITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [AW-1:0] dbg_addr,
  output logic [BW-1:0] dbg_data
);

  logic          rst_meta_n, rst_sync_n;
  logic [2:0]    pins_s;
  logic          cs_act, sck_s, mosi_s, sck_prev_q, sck_rise;
  logic          ram_ready;
  logic          eng_we;
  logic [BW-1:0] eng_wdata, ram_rdata;
  logic [AW-1:0] eng_addr;
  eng_state_t    eng_st;
  logic [CW-1:0] eng_cnt;
  logic [BW-2:0] eng_shlo;
  logic          eng_wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  eep_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({spi_cs_n, spi_sck, spi_mosi}),
    .q     (pins_s)
  );

  assign cs_act = !pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
    end
  end

  assign sck_rise = sck_s && !sck_prev_q;

  eep_ram #(.AW(AW), .DW(BW), .FILL('1)) u_ram (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ready   (ram_ready),
    .we      (eng_we),
    .waddr   (eng_addr),
    .wdata   (eng_wdata),
    .ra_addr (eng_addr),
    .ra_data (ram_rdata),
    .rb_addr (dbg_addr),
    .rb_data (dbg_data)
  );

  eep_engine #(.AW(AW), .BW(BW), .ABITS(ABITS)) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ready    (ram_ready),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .mosi     (mosi_s),
    .miso     (spi_miso),
    .we       (eng_we),
    .wdata    (eng_wdata),
    .addr_o   (eng_addr),
    .rdata    (ram_rdata),
    .st_o     (eng_st),
    .cnt_o    (eng_cnt),
    .shlo_o   (eng_shlo),
    .wel_o    (eng_wel)
  );

endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
#(
  parameter int AW = 12,
  parameter int BW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          sck_rise,
  input logic          ready,
  input logic          mosi_s,
  input eng_state_t    st,
  input logic [CW-1:0] cnt,
  input logic [BW-2:0] shlo,
  input logic          wel,
  input logic [AW-1:0] addr,
  input logic          we,
  input logic          miso
);

  logic          opc_done;
  logic [BW-1:0] opc;

  assign opc_done = cs_act && ready && sck_rise && (st == ST_IDLE) && (cnt == CW'(BW - 1));
  assign opc      = {shlo, mosi_s};

  AST_NOT_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (st == ST_IDLE)); // R1

  AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_done && opc == OP_LATCH_SET) |=> wel); // R2

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_done && (opc == OP_STAT_WR || opc == OP_DATA_WR || opc == OP_LATCH_CLR)) |=> !wel); // R6

  AST_STORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (cs_act && st == ST_WR_DATA)); // R5

  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && ready && sck_rise && st == ST_RD_DATA && cnt == CW'(BW - 1) && addr == '1)
      |=> (addr == '0)); // R7

  AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !miso); // R8

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (st == ST_IDLE && cnt == '0)); // R9

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act || !sck_rise || !ready) |=> $stable(wel)); // R11

endmodule

bind spi_eeprom_slave eep_chk #(.AW(AW), .BW(BW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cs_act   (cs_act),
  .sck_rise (sck_rise),
  .ready    (ram_ready),
  .mosi_s   (mosi_s),
  .st       (eng_st),
  .cnt      (eng_cnt),
  .shlo     (eng_shlo),
  .wel      (eng_wel),
  .addr     (eng_addr),
  .we       (eng_we),
  .miso     (spi_miso)
);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sck, mosi;
  logic        miso;
  logic [11:0] dbg_addr;
  logic [7:0]  dbg_data;

  int n_tests = 0;
  int n_fail  = 0;
  int quiet_err = 0;
  int cs_hi_run = 0;
  bit done = 0;

  logic [7:0] mem_m [4096];
  bit         wel_m;

  always #4 clk = ~clk;

  spi_eeprom_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (cs_n),
    .spi_sck  (sck),
    .spi_mosi (mosi),
    .spi_miso (miso),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  // per-clock comparison: serial out must be quiet once deselect has settled (R8)
  always @(negedge clk) begin
    if (!rst_n || !cs_n) cs_hi_run <= 0;
    else cs_hi_run <= cs_hi_run + 1;
    if (rst_n && cs_n && cs_hi_run >= 4 && miso !== 1'b0) quiet_err <= quiet_err + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clkn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic o);
    @(negedge clk); mosi = b;
    clkn(3); sck = 1'b1;
    clkn(6); sck = 1'b0;
    clkn(6); o = miso;
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    clkn(6);
  endtask

  task automatic desel();
    clkn(2); cs_n = 1'b1;
    clkn(8);
  endtask

  task automatic spi_bits(input logic [7:0] v, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      logic o;
      spi_bit(v[k], o);
    end
  endtask

  // behavioural reference: byte-level command interpreter over the model array
  task automatic model(input logic [7:0] din[$], output logic [7:0] dout[$]);
    int         ms = 0;
    int         nab = 0;
    int         ma = 0;
    logic [15:0] a16 = '0;
    logic [7:0]  stat = '0;
    dout = {};
    foreach (din[i]) begin
      logic [7:0] b;
      logic [7:0] ob;
      b = din[i];
      ob = 8'h00;
      case (ms)
        0: case (b)
             8'h01: begin if (wel_m) ms = 1; wel_m = 0; end
             8'h02: begin if (wel_m) begin ms = 5; nab = 0; end wel_m = 0; end
             8'h03: begin ms = 3; nab = 0; end
             8'h04: wel_m = 0;
             8'h05: begin ms = 2; stat = {6'b0, wel_m, 1'b0}; end
             8'h06: wel_m = 1;
             default: ;
           endcase
        1: ms = 0;
        2: begin ob = stat; ms = 0; end
        3, 5: begin
          a16 = {a16[7:0], b};
          nab++;
          if (nab == 2) begin
            ma = int'(a16) % 4096;
            ms = (ms == 3) ? 4 : 6;
          end
        end
        4: begin ob = mem_m[ma]; ma = (ma + 1) % 4096; end
        6: begin mem_m[ma] = b; ma = (ma + 1) % 4096; end
        default: ;
      endcase
      dout.push_back(ob);
    end
  endtask

  task automatic run_frame(input string tag, input logic [7:0] din[$]);
    logic [7:0] expq[$];
    model(din, expq);
    sel();
    foreach (din[i]) begin
      logic [7:0] got;
      for (int k = 7; k >= 0; k--) begin
        logic o;
        spi_bit(din[i][k], o);
        got[k] = o;
      end
      chk($sformatf("%s byte%0d", tag, i), {24'h0, got}, {24'h0, expq[i]});
    end
    desel();
  endtask

  task automatic dbg_chk(input string tag, input int a);
    @(negedge clk); dbg_addr = 12'(a);
    clkn(2);
    chk($sformatf("%s dbg[%03h]", tag, a), {24'h0, dbg_data}, {24'h0, mem_m[a]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'hFF;
    wel_m = 0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; dbg_addr = '0;
    clkn(5);
    rst_n = 1'b1;
    clkn(3);
    chk("R1 miso after reset", {31'h0, miso}, 32'h0);
    clkn(4200);

    // R1 / R10: fill contents through the debug port, latch clear in status
    dbg_chk("R1 R10", 0);
    dbg_chk("R1 R10", 4095);
    dbg_chk("R1 R10", 1234);
    run_frame("R1 status", '{8'h05, 8'h00});

    // R2: set, read, clear, read in one frame
    run_frame("R2 set/status", '{8'h06, 8'h05, 8'h00, 8'h04, 8'h05, 8'h00});
    run_frame("R2 set", '{8'h06});
    run_frame("R2 status", '{8'h05, 8'h00});

    // R3: unknown commands keep the latch (currently set) and stay in decode
    run_frame("R3 unknown", '{8'h00, 8'h07, 8'hFF, 8'hAA, 8'h05, 8'h00});

    // R4: write with masked address (0xF010 -> 0x010), then latch cleared
    run_frame("R4 write", '{8'h02, 8'hF0, 8'h10, 8'h11, 8'h22, 8'h33});
    dbg_chk("R4", 16'h010); dbg_chk("R4", 16'h011); dbg_chk("R4", 16'h012);
    run_frame("R4 latch after write", '{8'h05, 8'h00});

    // R4: write wrapping 0xFFE..0x001
    run_frame("R4 set", '{8'h06});
    run_frame("R4 wrap write", '{8'h02, 8'h8F, 8'hFE, 8'hA1, 8'hA2, 8'hA3, 8'hA4});
    dbg_chk("R4 wrap", 4094); dbg_chk("R4 wrap", 4095);
    dbg_chk("R4 wrap", 0);    dbg_chk("R4 wrap", 1);

    // R5: write with latch clear; following bytes decode as commands
    run_frame("R5 rejected write", '{8'h02, 8'h00, 8'h20, 8'h5A, 8'h05, 8'h00});
    dbg_chk("R5", 16'h020);
    run_frame("R5 decode after reject", '{8'h02, 8'h06, 8'h05, 8'h00});
    run_frame("R5 clear", '{8'h04});

    // R6: status write accepted swallows one byte; rejected one does not
    run_frame("R6 rejected", '{8'h01, 8'h06, 8'h05, 8'h00});
    run_frame("R6 accepted", '{8'h01, 8'h06, 8'h05, 8'h00});

    // R7: streamed reads, masked address, wrap, latch unchanged
    run_frame("R7 read", '{8'h03, 8'hC0, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    run_frame("R7 wrap read", '{8'h03, 8'h0F, 8'hFD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    run_frame("R7 set", '{8'h06});
    run_frame("R7 read keeps latch", '{8'h03, 8'h00, 8'h10, 8'h00, 8'h05, 8'h00});
    run_frame("R7 latch", '{8'h05, 8'h00});

    // R9: abort inside a write data byte (latch set above, consumed by 0x02)
    sel();
    spi_bits(8'h02, 8); spi_bits(8'h00, 8); spi_bits(8'h30, 8); spi_bits(8'h00, 4);
    desel();
    wel_m = 0;
    dbg_chk("R9 partial byte dropped", 16'h030);
    run_frame("R9 status after abort", '{8'h05, 8'h00});
    sel(); spi_bits(8'h00, 3); desel();
    run_frame("R9 realign set", '{8'h06});
    run_frame("R9 realign status", '{8'h05, 8'h00});
    run_frame("R9 clear", '{8'h04});

    // R11: clocking with chip select high does nothing
    spi_bits(8'h06, 8);
    run_frame("R11 status", '{8'h05, 8'h00});
    run_frame("R11 set", '{8'h06});
    spi_bits(8'h02, 8); spi_bits(8'h00, 8); spi_bits(8'h40, 8); spi_bits(8'h77, 8);
    dbg_chk("R11 array untouched", 16'h040);
    run_frame("R11 latch kept", '{8'h05, 8'h00});

    // R8 / R10: read back wrapped write data via the serial port and debug port
    run_frame("R8 R10 readback", '{8'h03, 8'h0F, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00});
    dbg_chk("R10", 16'h011);

    chk("R8 deselected miso quiet", quiet_err, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule